// File: doc/BRIEF.md
# Serial Controller Interrupt Status Unit

This block collects three event strobes from a serial controller (transmit finished, receive data ready, receive overflow) into a raw status register. It combines that raw status with enable bits held in a control register to build a masked status register, and from the masked status it drives one level-sensitive interrupt line. A small register interface lets software write the control and clear registers and read every register back.

The enable bits in the control register do not sit at the same positions as the status bits. They are permuted onto the status layout before masking. Software clears a raw event by writing a one at its bit position to the clear address. The masked status gathers bits over time and keeps them. Once a masked bit is set, only reset removes it, so the interrupt line stays high from then on.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the control register, raw status and masked status read zero and `irq` is low.
- R2: An event strobe sets its raw status bit on the next clock edge: transmit-done is bit 0, receive-ready is bit 1 and receive-overflow is bit 2.
- R3: A write to address 1 clears each raw status bit whose position holds a one in `wr_data[2:0]`, on the next edge. Raw bits written with zero keep their value.
- R4: If an event strobe and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: A write to address 0 loads the full control word. Control bit 5 enables status bit 0, control bit 4 enables status bit 1 and control bit 6 enables status bit 2. No other control bit affects masking.
- R6: On every edge each masked bit is ORed with the registered raw bit ANDed with its enable, so a masked bit follows its raw bit by one cycle. A masked bit stays set when the raw bit is cleared or the enable is removed, and only reset clears it.
- R7: `irq` is high in the same cycle that any masked status bit is set, with no register in between.
- R8: Writes to address 2 (raw) and address 3 (masked) change no register.
- R9: `rd_data` shows the selected register without a register stage. Address 0 gives the control word, address 2 the raw status, address 3 the masked status, each zero-extended, and address 1 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_tx_done | input | 1 | Transmit-done event strobe |
| evt_rx_ready | input | 1 | Receive-ready event strobe |
| evt_rx_ovf | input | 1 | Receive-overflow event strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| raw_status | output | 3 | Raw status bits |
| masked_status | output | 3 | Masked status bits |
| irq | output | 1 | Level interrupt, high while any masked bit is set |

## Verification
The hardest case to reach is an event strobe and a clear write that hit the same raw bit in the same cycle. A related hard case is a masked bit that must stay set after both its raw bit and its enable have gone away. Because masked bits only clear on reset, one long run would saturate `irq` early. The stimulus is therefore split into reset-separated phases. Each phase uses a sparse random event rate, random clears and random control words. Directed sequences place an event and a clear on the same bit in the same cycle, and they withdraw an enable after a masked bit has been captured.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NUM_EV   = 3;
  localparam int EV_TX    = 0;
  localparam int EV_RX    = 1;
  localparam int EV_OVF   = 2;
  localparam int ADDR_W   = 2;
  localparam int EN_LO    = 4;
  localparam int EN_HI    = 6;
  localparam int EN_W     = EN_HI - EN_LO + 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_RAW  = 2'd2;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd3;

  // control-register bit that enables a given status bit
  function automatic int en_pos(input int ev);
    case (ev)
      EV_TX:   return 5;
      EV_RX:   return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_remap.sv
module irq_enable_remap
  import irq_stat_pkg::*;
(
  input  logic [EN_W-1:0]   en_field,
  output logic [NUM_EV-1:0] en_status
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_map
    localparam int SRC = en_pos(i) - EN_LO;
    assign en_status[i] = en_field[SRC];
  end
endmodule

// File: rtl/irq_raw_reg.sv
module irq_raw_reg
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] evt,
  input  logic [NUM_EV-1:0] clr,
  output logic [NUM_EV-1:0] raw_q
);
  logic [NUM_EV-1:0] raw_d;
  logic              upd;

  always_comb begin
    upd   = (|clr) | (|evt);
    // set dominates clear so a coincident event is never lost
    raw_d = (raw_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   raw_q <= '0;
    else if (upd) raw_q <= raw_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] raw,
  input  logic [NUM_EV-1:0] en,
  output logic [NUM_EV-1:0] masked_q
);
  logic [NUM_EV-1:0] set_v;
  logic [NUM_EV-1:0] masked_d;
  logic              upd;

  always_comb begin
    set_v    = raw & en;
    upd      = |set_v;
    masked_d = masked_q | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   masked_q <= '0;
    else if (upd) masked_q <= masked_d;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_tx_done,
  input  logic              evt_rx_ready,
  input  logic              evt_rx_ovf,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        raw_status,
  output logic [2:0]        masked_status,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NUM_EV;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_we;
  logic              clr_we;
  logic [NUM_EV-1:0] evt_v;
  logic [NUM_EV-1:0] clr_v;
  logic [NUM_EV-1:0] en_v;
  logic [NUM_EV-1:0] raw_v;
  logic [NUM_EV-1:0] masked_v;

  always_comb begin
    evt_v         = '0;
    evt_v[EV_TX]  = evt_tx_done;
    evt_v[EV_RX]  = evt_rx_ready;
    evt_v[EV_OVF] = evt_rx_ovf;
    ctrl_we       = wr_en && (wr_addr == A_CTRL);
    clr_we        = wr_en && (wr_addr == A_CLR);
    clr_v         = clr_we ? wr_data[NUM_EV-1:0] : '0;
    ctrl_d        = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  irq_enable_remap u_remap (
    .en_field  (ctrl_q[EN_HI:EN_LO]),
    .en_status (en_v)
  );

  irq_raw_reg u_raw (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_v),
    .clr   (clr_v),
    .raw_q (raw_v)
  );

  irq_mask_reg u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (raw_v),
    .en       (en_v),
    .masked_q (masked_v)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl_q;
      A_RAW:   rd_data = {{PAD_W{1'b0}}, raw_v};
      A_MASK:  rd_data = {{PAD_W{1'b0}}, masked_v};
      default: rd_data = '0;
    endcase
  end

  assign raw_status    = raw_v;
  assign masked_status = masked_v;
  assign irq           = |masked_v;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] evt,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [2:0] wr_lo,
  input logic [6:4] ctrl_en,
  input logic [2:0] raw,
  input logic [2:0] masked,
  input logic       irq
);
  logic [2:0] en_chk;
  logic       clr_w;
  logic       ro_w;
  assign en_chk = {ctrl_en[6], ctrl_en[4], ctrl_en[5]};
  assign clr_w  = wr_en && (wr_addr == 2'd1);
  assign ro_w   = wr_en && (wr_addr[1] == 1'b1);

  // R2
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));
  // R3
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> ((raw & $past(wr_lo & ~evt)) == 3'b000));
  // R4
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && |(wr_lo & evt)) |=> ((raw & $past(wr_lo & evt)) == $past(wr_lo & evt)));
  // R6
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((masked & $past(masked)) == $past(masked)));
  // R5, R6
  a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((masked & ~$past(masked) & ~$past(raw & en_chk)) == 3'b000));
  // R7
  a_r7_irq_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(irq));
  // R8
  a_r8_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_w && !clr_w) |=> ((raw & $past(raw)) == $past(raw)));
endmodule

bind irq_status_unit irq_status_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     ({evt_rx_ovf, evt_rx_ready, evt_tx_done}),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_lo   (wr_data[2:0]),
  .ctrl_en (ctrl_q[6:4]),
  .raw     (raw_status),
  .masked  (masked_status),
  .irq     (irq)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  localparam int DW = 32;
  logic clk = 1'b0;
  logic rst_n;
  logic evt_tx_done, evt_rx_ready, evt_rx_ovf;
  logic wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic [2:0] raw_status, masked_status;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] m_ctrl;
  logic [2:0] m_raw, m_msk;

  always #2 clk = ~clk;

  irq_status_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .evt_tx_done(evt_tx_done), .evt_rx_ready(evt_rx_ready), .evt_rx_ovf(evt_rx_ovf),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [2:0] m_en(input logic [DW-1:0] c);
    // control 5 -> status 0, control 4 -> status 1, control 6 -> status 2
    return {c[6], c[4], c[5]};
  endfunction

  function automatic logic [DW-1:0] m_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd2: return {29'd0, m_raw};
      2'd3: return {29'd0, m_msk};
      default: return '0;
    endcase
  endfunction

  task automatic compare(input string raw_tag);
    chk(raw_status === m_raw, raw_tag, {29'd0, raw_status}, {29'd0, m_raw});
    chk(masked_status === m_msk, "R6 masked", {29'd0, masked_status}, {29'd0, m_msk});
    chk(irq === (|m_msk), "R7 irq", {31'd0, irq}, {31'd0, |m_msk});
    chk(rd_data === m_rd(rd_addr), "R9 readback", rd_data, m_rd(rd_addr));
  endtask

  // one clock; inputs already set at a negedge
  task automatic tick();
    logic [2:0] ev, cl;
    logic [DW-1:0] c_n;
    logic [2:0] r_n, k_n;
    string tag;
    ev  = {evt_rx_ovf, evt_rx_ready, evt_tx_done};
    cl  = (wr_en && wr_addr == 2'd1) ? wr_data[2:0] : 3'b000;
    c_n = (wr_en && wr_addr == 2'd0) ? wr_data : m_ctrl;
    r_n = (m_raw & ~cl) | ev;
    k_n = m_msk | (m_raw & m_en(m_ctrl));
    if (|(cl & ev))                   tag = "R4 event beats clear";
    else if (|cl)                     tag = "R3 clear";
    else if (wr_en && wr_addr[1])     tag = "R8 read-only write";
    else                              tag = "R2 raw";
    @(posedge clk);
    m_ctrl = c_n; m_raw = r_n; m_msk = k_n;
    @(negedge clk);
    cyc++;
    compare(tag);
  endtask

  task automatic idle();
    evt_tx_done = 0; evt_rx_ready = 0; evt_rx_ovf = 0;
    wr_en = 0; wr_addr = 0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle();
    m_ctrl = '0; m_raw = '0; m_msk = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      rd_addr = a[1:0]; #0.1;
      chk(rd_data === '0, "R1 reset readback", rd_data, '0);
    end
    chk(irq === 1'b0, "R1 reset irq", {31'd0, irq}, '0);
    chk(raw_status === 3'b0 && masked_status === 3'b0, "R1 reset status",
        {26'd0, masked_status, raw_status}, '0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    idle(); wr_en = 1; wr_addr = a; wr_data = d; tick(); idle();
  endtask

  initial begin
    rst_n = 0; idle(); rd_addr = 0;
    do_reset();

    // R5: enable only receive-ready (control bit 4), fire all events
    rd_addr = 2'd0;
    wr(2'd0, 32'h0000_0010);
    evt_tx_done = 1; evt_rx_ready = 1; evt_rx_ovf = 1; tick(); idle();
    tick();
    chk(masked_status === 3'b010, "R5 remap bit4->status1", {29'd0, masked_status}, 32'h2);
    // R6: clear raw and drop enable, masked stays
    wr(2'd1, 32'h7);
    wr(2'd0, 32'h0);
    tick();
    chk(masked_status === 3'b010, "R6 sticky after clear", {29'd0, masked_status}, 32'h2);
    chk(raw_status === 3'b000, "R3 all cleared", {29'd0, raw_status}, '0);

    // R4: event and clear on the same bit in the same cycle
    do_reset();
    evt_rx_ovf = 1; tick(); idle();
    evt_rx_ovf = 1; wr_en = 1; wr_addr = 2'd1; wr_data = 32'h4; tick(); idle();
    chk(raw_status[2] === 1'b1, "R4 overflow kept", {29'd0, raw_status}, 32'h4);
    // R8: writes to raw / masked addresses ignored
    rd_addr = 2'd2;
    wr(2'd2, 32'h0); wr(2'd3, 32'hFFFF_FFFF);
    chk(raw_status === 3'b100 && masked_status === 3'b000, "R8 ignored",
        {26'd0, masked_status, raw_status}, 32'h4);
    // R5: control bit 5 -> status 0, bit 6 -> status 2
    wr(2'd0, 32'hFFFF_FF8F); tick();
    chk(masked_status === 3'b000, "R5 unrelated ctrl bits", {29'd0, masked_status}, '0);
    wr(2'd0, 32'h0000_0040); tick();
    chk(masked_status === 3'b100, "R5 bit6->status2", {29'd0, masked_status}, 32'h4);
    wr(2'd0, 32'h0000_0020); evt_tx_done = 1; tick(); idle(); tick();
    chk(masked_status === 3'b101, "R5 bit5->status0", {29'd0, masked_status}, 32'h5);

    // random phases, reset between them
    for (int ph = 0; ph < 6; ph++) begin
      do_reset();
      for (int k = 0; k < 300; k++) begin
        int r;
        idle();
        r = $urandom_range(0, 99);
        evt_tx_done  = ($urandom_range(0, 29) == 0);
        evt_rx_ready = ($urandom_range(0, 29) == 0);
        evt_rx_ovf   = ($urandom_range(0, 29) == 0);
        if (r < 20) begin
          wr_en = 1; wr_addr = 2'd1; wr_data = $urandom();
        end else if (r < 26) begin
          wr_en = 1; wr_addr = 2'd0;
          wr_data = (ph < 3) ? ($urandom() & ~32'h70) | (32'h10 << (ph)) : $urandom();
        end else if (r < 34) begin
          wr_en = 1; wr_addr = 2'($urandom_range(2, 3)); wr_data = $urandom();
        end
        rd_addr = 2'($urandom_range(0, 3));
        tick();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule